// File: doc/BRIEF.md
# Per-Bit Access-Policy Register Bank

This block is a small bank of control and status registers reached over a plain synchronous bus: one address, a write strobe with write data, and a read strobe with combinational read data. Every bit of the bank is given its own access policy by a parameter. A bit can store software values, mirror a hardware signal, hold hardware events until software clears them by writing or reading, latch a high or low condition until read, or pulse and recover on its own.

Hardware feeds one input bit per bank bit (`hw_in`, bit index = register × DATA_W + bit). It is the live value, event or condition for that position. The whole bank is visible on `ctrl_out` with the same indexing. A software-reset input returns ordinary bits to their defaults and leaves bits flagged as exempt alone. The asynchronous hardware reset restores every bit. Read side effects land on the clock edge that samples the read, so a read always returns the value from before the clear.

Policy codes (4 bits per bit): 0 reserved, 1 read/write, 2 read-only, 3 write-only, 4 write-1-to-clear, 5 write-any-to-clear, 6 read-to-clear, 7 latch-high, 8 latch-low, 9 self-clearing, 10 self-setting. The default layout is used in the requirements below.

Top module: `regbank_top`

## Requirements
- R1: Register 0 bits [3:0] are read/write. A write stores the data, a read of address 0 returns it, and `ctrl_out[3:0]` shows it from the cycle after the write.
- R2: Register 1 bits [3:0] are read-only. They hold `hw_in[11:8]` as sampled on the previous clock edge, and bus writes do not change them.
- R3: Register 0 bits [5:4] are write-only. Writes reach `ctrl_out[5:4]`, but reads return 0 there. Register 1 bits [7:4] are reserved: they read 0, writes are discarded, and `ctrl_out[15:12]` stays 0.
- R4: Register 2 bits [3:0] are write-1-to-clear. They are set by a high `hw_in[19:16]`, cleared by writing 1, and left unchanged by writing 0.
- R5: Register 2 bits [7:4] are write-any-to-clear. They are set by `hw_in[23:20]` and cleared by any write to address 2, whatever the data.
- R6: Register 3 bits [3:0] are read-to-clear. They are set by `hw_in[27:24]`. A read returns the set value and clears the bits on the same edge. Writes have no effect on them.
- R7: Register 3 bits [5:4] are latch-high on `hw_in[29:28]`. Once the condition is seen high, the bit stays 1 until address 3 is read. After the read it takes the live condition.
- R8: Register 3 bits [7:6] are latch-low on `hw_in[31:30]`, with reset value 1. Once the condition is seen low, the bit stays 0 until address 3 is read. After the read it takes the live condition.
- R9: Register 0 bit 6 is self-clearing. Writing 1 makes it 1 for exactly one cycle. Writing 0 has no effect.
- R10: Register 0 bit 7 is self-setting, with reset value 1. Writing 0 makes it 0 for exactly one cycle. Writing 1 has no effect.
- R11: When a hardware event arrives in the same cycle as a clearing write or read of its bit, the event wins and the bit stays 1.
- R12: A one-cycle `sw_rst` returns non-exempt bits to their reset values. Register 0 bits [3:2] are exempt and keep their value.
- R13: Asserting `rst_n` low returns every bit to its reset value, exempt bits included. The default reset image on `ctrl_out` is 32'hC0000080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset, skips exempt bits |
| addr | input | ADDR_W | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe, also triggers read side effects |
| rd_data | output | DATA_W | Read data, combinational, 0 when no read |
| hw_in | input | 2**ADDR_W*DATA_W | Hardware value, event or condition per bit |
| ctrl_out | output | 2**ADDR_W*DATA_W | Current value of every bank bit |

## Verification
The hardest situations to reach from the ports are the collisions: a hardware event in the very cycle a read or write clears its bit, and a latch-high condition that is still high when the releasing read lands. The bench drives `hw_in` and the bus strobe at the same falling edge, so both reach the same rising edge. It then checks `ctrl_out` one cycle later. The latch cases pulse the condition for a single cycle and read several cycles afterwards. This separates a true latch from a plain mirror of the input.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    typedef enum logic [3:0] {
        POL_RSVD = 4'd0,
        POL_RW   = 4'd1,
        POL_RO   = 4'd2,
        POL_WO   = 4'd3,
        POL_W1C  = 4'd4,
        POL_WAC  = 4'd5,
        POL_RC   = 4'd6,
        POL_LH   = 4'd7,
        POL_LL   = 4'd8,
        POL_SC   = 4'd9,
        POL_SS   = 4'd10
    } policy_e;

    function automatic logic is_readable(input logic [3:0] code);
        return !(code == POL_RSVD || code == POL_WO || code > POL_SS);
    endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
    parameter int ADDR_W   = 2,
    parameter int NUM_REGS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [NUM_REGS-1:0] wr_hit,
    output logic [NUM_REGS-1:0] rd_hit
);

    always_comb begin
        wr_hit = '0;
        rd_hit = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (addr == ADDR_W'(r)) begin
                wr_hit[r] = wr_en;
                rd_hit[r] = rd_en;
            end
        end
    end

    AST_WR_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $countones(wr_hit) == 1); // R1
    AST_RD_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> $countones(rd_hit) == 1); // R6
    AST_NO_STRAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> wr_hit == '0); // R3

endmodule

// File: rtl/regbank_bit.sv
module regbank_bit
    import regbank_pkg::*;
#(
    parameter policy_e POL     = POL_RW,
    parameter logic    RST_VAL = 1'b0,
    parameter logic    EXEMPT  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic wr_hit,
    input  logic rd_hit,
    input  logic wr_bit,
    input  logic hw_bit,
    output logic val
);

    logic val_d, val_q;

    always_comb begin
        val_d = val_q;
        case (POL)
            POL_RW, POL_WO: if (wr_hit) val_d = wr_bit;
            POL_RO:  val_d = hw_bit;
            POL_W1C: val_d = hw_bit | (val_q & ~(wr_hit & wr_bit));
            POL_WAC: val_d = hw_bit | (val_q & ~wr_hit);
            POL_RC:  val_d = hw_bit | (val_q & ~rd_hit);
            POL_LH:  val_d = rd_hit ? hw_bit : (val_q | hw_bit);
            POL_LL:  val_d = rd_hit ? hw_bit : (val_q & hw_bit);
            POL_SC:  val_d = wr_hit & wr_bit;
            POL_SS:  val_d = ~(wr_hit & ~wr_bit);
            default: val_d = 1'b0;
        endcase
        if (sw_rst && !EXEMPT) val_d = RST_VAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RST_VAL;
        else        val_q <= val_d;
    end

    assign val = val_q;

    logic unused_inputs;
    assign unused_inputs = ^{wr_hit, rd_hit, wr_bit, hw_bit};

    generate
        if (POL == POL_RO) begin : g_ro_chk
            AST_RO_FOLLOWS_HW: assert property (@(posedge clk) disable iff (!rst_n)
                !sw_rst |=> val_q == $past(hw_bit)); // R2
        end
        if (POL == POL_W1C) begin : g_w1c_chk
            AST_W1C_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (val_q && wr_hit && !wr_bit && !sw_rst) |=> val_q); // R4
        end
        if (POL == POL_RC) begin : g_rc_chk
            AST_RC_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
                (val_q && !rd_hit && !sw_rst) |=> val_q); // R6
        end
        if (POL == POL_LH) begin : g_lh_chk
            AST_LH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (val_q && !rd_hit && !sw_rst) |=> val_q); // R7
        end
        if (POL == POL_LL) begin : g_ll_chk
            AST_LL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (!val_q && !rd_hit && !sw_rst) |=> !val_q); // R8
        end
        if (POL == POL_SC) begin : g_sc_chk
            AST_SC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                (val_q && !(wr_hit && wr_bit)) |=> !val_q); // R9
        end
        if (POL == POL_SS) begin : g_ss_chk
            AST_SS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                (!val_q && !(wr_hit && !wr_bit)) |=> val_q); // R10
        end
        if (EXEMPT && (POL == POL_RW)) begin : g_ex_chk
            AST_EXEMPT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (sw_rst && !wr_hit) |=> $stable(val_q)); // R12
        end
    endgenerate

endmodule

// File: rtl/regbank_readmux.sv
module regbank_readmux
    import regbank_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 4,
    parameter logic [NUM_REGS*DATA_W*4-1:0] POLICY = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       rd_en,
    input  logic [NUM_REGS*DATA_W-1:0] bits,
    output logic [DATA_W-1:0]          rd_data
);

    localparam int TOTAL = NUM_REGS * DATA_W;

    logic [TOTAL-1:0]  visible;
    logic [DATA_W-1:0] reg_view [NUM_REGS];

    genvar i;
    generate
        for (i = 0; i < TOTAL; i++) begin : g_mask
            localparam logic READABLE = is_readable(POLICY[i*4 +: 4]);
            assign visible[i] = READABLE & bits[i];
            if (!READABLE) begin : g_hide_chk
                AST_HIDDEN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                    (rd_en && addr == ADDR_W'(i / DATA_W)) |-> !rd_data[i % DATA_W]); // R3
            end
        end
        for (i = 0; i < NUM_REGS; i++) begin : g_view
            assign reg_view[i] = visible[i*DATA_W +: DATA_W];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_en) rd_data = reg_view[addr];
    end

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0); // R3

endmodule

// File: rtl/regbank_top.sv
module regbank_top
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    parameter logic [(2**ADDR_W)*DATA_W*4-1:0] POLICY =
        128'h88776666_55554444_00002222_A9331111,
    parameter logic [(2**ADDR_W)*DATA_W-1:0] RESET_VAL = 32'hC000_0080,
    parameter logic [(2**ADDR_W)*DATA_W-1:0] SW_EXEMPT = 32'h0000_000C
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sw_rst,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           wr_en,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           rd_en,
    output logic [DATA_W-1:0]              rd_data,
    input  logic [(2**ADDR_W)*DATA_W-1:0]  hw_in,
    output logic [(2**ADDR_W)*DATA_W-1:0]  ctrl_out
);

    localparam int NUM_REGS = 2 ** ADDR_W;
    localparam int TOTAL    = NUM_REGS * DATA_W;

    logic [NUM_REGS-1:0] wr_hit, rd_hit;
    logic [TOTAL-1:0]    bits_q;

    regbank_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    genvar i;
    generate
        for (i = 0; i < TOTAL; i++) begin : g_bit
            regbank_bit #(
                .POL     (policy_e'(POLICY[i*4 +: 4])),
                .RST_VAL (RESET_VAL[i]),
                .EXEMPT  (SW_EXEMPT[i])
            ) u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .sw_rst (sw_rst),
                .wr_hit (wr_hit[i / DATA_W]),
                .rd_hit (rd_hit[i / DATA_W]),
                .wr_bit (wr_data[i % DATA_W]),
                .hw_bit (hw_in[i]),
                .val    (bits_q[i])
            );
        end
    endgenerate

    regbank_readmux #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .POLICY   (POLICY)
    ) u_readmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .rd_en   (rd_en),
        .bits    (bits_q),
        .rd_data (rd_data)
    );

    assign ctrl_out = bits_q;

    AST_HW_RESET_IMAGE: assert property (@(posedge clk)
        $rose(rst_n) |-> ctrl_out == RESET_VAL); // R13

endmodule

// File: tb/tb_regbank_top.sv
module tb_regbank_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [31:0] hw_in = 32'hC000_0000;
    logic [31:0] ctrl_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    regbank_top dut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .hw_in(hw_in), .ctrl_out(ctrl_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic hw_pulse(input logic [31:0] m);
        @(negedge clk); hw_in = hw_in | m;
        @(negedge clk); hw_in = hw_in & ~m;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        idle(1);
        check("R13 reset image", ctrl_out, 32'hC000_0080);
    endtask

    task automatic t_rw_wo_rsvd;
        logic [7:0] d;
        bus_write(2'd0, 8'h8A);
        check("R1 ctrl_out rw", {28'h0, ctrl_out[3:0]}, 32'hA);
        bus_read(2'd0, d);
        check("R1 read rw", {24'h0, d}, 32'h8A);
        bus_write(2'd0, 8'hB5);
        check("R3 wo on ctrl_out", {24'h0, ctrl_out[7:0]}, 32'hB5);
        bus_read(2'd0, d);
        check("R3 wo reads zero", {24'h0, d}, 32'h85);
        bus_write(2'd1, 8'hFF);
        check("R3 reserved discarded", {28'h0, ctrl_out[15:12]}, 32'h0);
        bus_read(2'd1, d);
        check("R3 reserved reads zero", {28'h0, d[7:4]}, 32'h0);
    endtask

    task automatic t_ro;
        logic [7:0] d;
        @(negedge clk); hw_in[11:8] = 4'h6;
        idle(1);
        bus_write(2'd1, 8'h09);
        bus_read(2'd1, d);
        check("R2 ro tracks hw, ignores write", {24'h0, d}, 32'h06);
        @(negedge clk); hw_in[11:8] = 4'h0;
    endtask

    task automatic t_w1c_wac;
        hw_pulse(32'h000F_0000);
        check("R4 w1c set", {28'h0, ctrl_out[19:16]}, 32'hF);
        bus_write(2'd2, 8'h05);
        check("R4 w1c clears ones", {28'h0, ctrl_out[19:16]}, 32'hA);
        bus_write(2'd2, 8'h00);
        check("R4 w1c zero keeps", {28'h0, ctrl_out[19:16]}, 32'hA);
        hw_pulse(32'h00F0_0000);
        check("R5 wac set", {24'h0, ctrl_out[23:16]}, 32'hFA);
        bus_write(2'd2, 8'h00);
        check("R5 wac any write clears", {24'h0, ctrl_out[23:16]}, 32'h0A);
    endtask

    task automatic t_rc;
        logic [7:0] d;
        hw_pulse(32'h0300_0000);
        bus_write(2'd3, 8'hFF);
        check("R6 rc write ignored", {28'h0, ctrl_out[27:24]}, 32'h3);
        bus_read(2'd3, d);
        check("R6 rc read returns value", {24'h0, d}, 32'hC3);
        check("R6 rc cleared after read", {28'h0, ctrl_out[27:24]}, 32'h0);
    endtask

    task automatic t_latch;
        logic [7:0] d;
        hw_pulse(32'h1000_0000);
        idle(3);
        check("R7 lh holds after drop", {31'h0, ctrl_out[28]}, 32'h1);
        bus_read(2'd3, d);
        check("R7 lh read shows event", {31'h0, d[4]}, 32'h1);
        check("R7 lh released", {31'h0, ctrl_out[28]}, 32'h0);
        @(negedge clk); hw_in[29] = 1'b1;
        idle(1);
        bus_read(2'd3, d);
        check("R7 lh stays while high", {31'h0, ctrl_out[29]}, 32'h1);
        @(negedge clk); hw_in[29] = 1'b0;
        idle(2);
        check("R7 lh latched after drop", {31'h0, ctrl_out[29]}, 32'h1);
        bus_read(2'd3, d);
        check("R7 lh follows low after read", {31'h0, ctrl_out[29]}, 32'h0);
        @(negedge clk); hw_in[30] = 1'b0;
        @(negedge clk); hw_in[30] = 1'b1;
        idle(2);
        check("R8 ll holds low", {31'h0, ctrl_out[30]}, 32'h0);
        bus_read(2'd3, d);
        check("R8 ll read shows low", {31'h0, d[6]}, 32'h0);
        check("R8 ll released high", {31'h0, ctrl_out[30]}, 32'h1);
    endtask

    task automatic t_sc_ss;
        bus_write(2'd0, 8'hCA);
        check("R9 sc set", {31'h0, ctrl_out[6]}, 32'h1);
        idle(1);
        check("R9 sc back to zero", {31'h0, ctrl_out[6]}, 32'h0);
        bus_write(2'd0, 8'h0A);
        check("R10 ss cleared", {31'h0, ctrl_out[7]}, 32'h0);
        idle(1);
        check("R10 ss back to one", {31'h0, ctrl_out[7]}, 32'h1);
        check("R9 sc zero write ignored", {31'h0, ctrl_out[6]}, 32'h0);
    endtask

    task automatic t_collide;
        logic [7:0] d;
        @(negedge clk); addr = 2'd2; wr_data = 8'h01; wr_en = 1'b1; hw_in[16] = 1'b1;
        @(negedge clk); wr_en = 1'b0; hw_in[16] = 1'b0;
        check("R11 w1c event beats clear", {31'h0, ctrl_out[16]}, 32'h1);
        @(negedge clk); addr = 2'd3; rd_en = 1'b1; hw_in[24] = 1'b1;
        #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0; hw_in[24] = 1'b0;
        check("R11 rc event beats read clear", {31'h0, ctrl_out[24]}, 32'h1);
    endtask

    task automatic t_swrst;
        bus_write(2'd0, 8'h8F);
        @(negedge clk); sw_rst = 1'b1;
        @(negedge clk); sw_rst = 1'b0;
        check("R12 exempt kept, others reset", {28'h0, ctrl_out[3:0]}, 32'hC);
        check("R12 w1c reset", {28'h0, ctrl_out[19:16]}, 32'h0);
        check("R12 rc reset", {28'h0, ctrl_out[27:24]}, 32'h0);
    endtask

    task automatic t_hwrst;
        logic [7:0] d;
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        check("R13 hw reset clears exempt", ctrl_out, 32'hC000_0080);
        bus_read(2'd0, d);
        check("R13 read after hw reset", {24'h0, d}, 32'h80);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        t_reset();
        t_rw_wo_rsvd();
        t_ro();
        t_w1c_wac();
        t_rc();
        t_latch();
        t_sc_ss();
        t_collide();
        t_swrst();
        t_hwrst();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule